// File: doc/BRIEF.md
# Host-DSP Mailbox with Interrupt Handshake

This block passes 16-bit words in both directions between a host processor and a DSP. Each direction has one holding register and one full flag: a writer fills the register and raises the flag, the matching reader takes the word and drops the flag. Words from the host also carry a one-bit tag taken from the host address, which lets the DSP tell commands from data.

The DSP interrupt request is built from both full flags and a pair of complementary enables. Only the enable for the DSP-to-host flag is stored; the enable for the host-to-DSP flag is always its inverse. The DSP can also drive an interrupt bit toward the host. Both sides get a status word.

A host control bit holds the DSP in reset. When that bit rises, the handshake state returns to its start-up values, except for the host-to-DSP flag, which only the system reset clears.

Top module: `dsp_mailbox`

## Requirements
- R1: A host write strobe (`host_wr`) stores `host_wdata` in the host-to-DSP register, sets the host-to-DSP flag and stores `host_tag` as the command tag.
- R2: A DSP read strobe at address 0 returns the host-to-DSP word on `dsp_rdata` in the same cycle and clears the host-to-DSP flag on the next edge.
- R3: A DSP write strobe at address 0 stores `dsp_wdata` and sets the DSP-to-host flag. `host_rdata` always shows that word, and a host read strobe (`host_rd`) clears the flag.
- R4: A DSP write at address 3 loads bit 1 of `dsp_wdata` into the DSP-flag interrupt enable. The host-flag enable is always its complement.
- R5: `dsp_irq` is high exactly when neither (host-to-DSP flag clear AND host-flag enable) nor (DSP-to-host flag set AND DSP-flag enable) holds.
- R6: A DSP write at address 1 loads bit 1 of `dsp_wdata` into `host_irq`.
- R7: `host_status` has bits 11..0 all ones, bit 15 = host-to-DSP flag, bit 14 = DSP-to-host flag, bit 13 = host-flag enable, bit 12 = NOT `host_irq`.
- R8: A DSP read at address 1 returns bits 11..0 all ones, bit 15 = command tag, bit 14 = host-to-DSP flag, bit 13 = DSP-to-host flag, bit 12 = 0. Any DSP address other than 0 and 1 reads as 0.
- R9: A host control write (`host_ctl_wr`) loads `host_ctl_run` into `dsp_run`. When `dsp_run` goes from 0 to 1, the DSP-to-host flag, the tag and the DSP-flag enable clear, and this wins over any same-cycle DSP write. A control write that leaves `dsp_run` at 1 changes nothing else. The host-to-DSP flag is left alone.
- R10: When a set and a clear of the same full flag fall in the same cycle, the flag ends up set.
- R11: After the asynchronous reset, all flags, the tag, the DSP-flag enable, `host_irq` and `dsp_run` are 0. `host_status` then reads 0x3FFF and `dsp_irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host write strobe for the data port |
| host_tag | input | 1 | Command tag for the host write (host address bit 0) |
| host_wdata | input | 16 | Host write data |
| host_rd | input | 1 | Host read strobe for the data port |
| host_rdata | output | 16 | DSP-to-host word |
| host_status | output | 16 | Host status word |
| host_irq | output | 1 | Interrupt request toward the host |
| host_ctl_wr | input | 1 | Host control write strobe |
| host_ctl_run | input | 1 | Control value: 1 releases the DSP from reset |
| dsp_run | output | 1 | DSP reset release level |
| dsp_rd | input | 1 | DSP read strobe |
| dsp_wr | input | 1 | DSP write strobe |
| dsp_addr | input | 3 | DSP register address |
| dsp_wdata | input | 16 | DSP write data |
| dsp_rdata | output | 16 | DSP read data |
| dsp_irq | output | 1 | Interrupt request to the DSP |

## Verification
Random cycles mix host and DSP strobes at every address with control writes, so every pairing of the two flags with both enable values reaches the interrupt term. This separates the flag logic from the enable logic in the R5 expression. Directed cases then cover the reset values, a set and a clear of the same flag in one cycle, and a release edge while the host flag is full. They also cover a repeated control write with the bit already at 1, which must clear nothing. That last case is what separates edge detection from a level-triggered release.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int unsigned MBX_AW       = 3;
  localparam int unsigned REG_DATA_IDX = 0;
  localparam int unsigned REG_STAT_IDX = 1;
  localparam int unsigned REG_IEN_IDX  = 3;
  localparam int unsigned NUM_DIRS     = 2;
  localparam int unsigned DIR_H2D      = 0;
  localparam int unsigned DIR_D2H      = 1;

  typedef struct packed {
    logic h2d_full;
    logic d2h_full;
    logic tag;
    logic dsp_en;
    logic hirq;
  } mbx_view_t;
endpackage

// File: rtl/mbx_flag.sv
module mbx_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  input  logic kill_i,
  output logic q_o
);
  logic q_d, q_q;

  always_comb begin
    q_d = q_q;
    if (kill_i)     q_d = 1'b0;
    else if (set_i) q_d = 1'b1;
    else if (clr_i) q_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_q <= 1'b0;
    else        q_q <= q_d;
  end

  assign q_o = q_q;
endmodule

// File: rtl/mbx_word.sv
module mbx_word #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_d, q_q;

  always_comb begin
    q_d = q_q;
    if (we_i) q_d = d_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_q <= '0;
    else        q_q <= q_d;
  end

  assign q_o = q_q;
endmodule

// File: rtl/mbx_ctrl.sv
module mbx_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic host_wr_i,
  input  logic host_tag_i,
  input  logic ien_we_i,
  input  logic hirq_we_i,
  input  logic wbit_i,
  input  logic ctl_wr_i,
  input  logic ctl_run_i,
  output logic tag_o,
  output logic dsp_en_o,
  output logic hirq_o,
  output logic run_o,
  output logic release_o
);
  logic tag_d, tag_q, en_d, en_q, hirq_d, hirq_q, run_d, run_q;
  logic rel;

  assign rel = ctl_wr_i && ctl_run_i && !run_q;

  always_comb begin
    tag_d  = tag_q;
    en_d   = en_q;
    hirq_d = hirq_q;
    run_d  = run_q;
    if (ctl_wr_i)  run_d  = ctl_run_i;
    if (hirq_we_i) hirq_d = wbit_i;
    if (rel) begin
      tag_d = 1'b0;
      en_d  = 1'b0;
    end else begin
      if (host_wr_i) tag_d = host_tag_i;
      if (ien_we_i)  en_d  = wbit_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tag_q  <= 1'b0;
      en_q   <= 1'b0;
      hirq_q <= 1'b0;
      run_q  <= 1'b0;
    end else begin
      tag_q  <= tag_d;
      en_q   <= en_d;
      hirq_q <= hirq_d;
      run_q  <= run_d;
    end
  end

  assign tag_o     = tag_q;
  assign dsp_en_o  = en_q;
  assign hirq_o    = hirq_q;
  assign run_o     = run_q;
  assign release_o = rel;
endmodule

// File: rtl/dsp_mailbox.sv
module dsp_mailbox
  import mbx_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = MBX_AW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic              host_tag,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic              host_rd,
  output logic [DATA_W-1:0] host_rdata,
  output logic [DATA_W-1:0] host_status,
  output logic              host_irq,
  input  logic              host_ctl_wr,
  input  logic              host_ctl_run,
  output logic              dsp_run,
  input  logic              dsp_rd,
  input  logic              dsp_wr,
  input  logic [ADDR_W-1:0] dsp_addr,
  input  logic [DATA_W-1:0] dsp_wdata,
  output logic [DATA_W-1:0] dsp_rdata,
  output logic              dsp_irq
);
  localparam int unsigned LOW_W = DATA_W - 4;
  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(REG_DATA_IDX);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(REG_STAT_IDX);
  localparam logic [ADDR_W-1:0] A_IEN  = ADDR_W'(REG_IEN_IDX);

  logic              at_data, at_stat, at_ien;
  logic [NUM_DIRS-1:0] f_set, f_clr, f_kill, f_q;
  logic [DATA_W-1:0] h2d_word, d2h_word;
  logic              rel;
  mbx_view_t         v;

  assign at_data = (dsp_addr == A_DATA);
  assign at_stat = (dsp_addr == A_STAT);
  assign at_ien  = (dsp_addr == A_IEN);

  assign f_set[DIR_H2D]  = host_wr;
  assign f_clr[DIR_H2D]  = dsp_rd && at_data;
  assign f_kill[DIR_H2D] = 1'b0;
  assign f_set[DIR_D2H]  = dsp_wr && at_data;
  assign f_clr[DIR_D2H]  = host_rd;
  assign f_kill[DIR_D2H] = rel;

  for (genvar g = 0; g < NUM_DIRS; g++) begin : g_flag
    mbx_flag u_flag (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (f_set[g]),
      .clr_i  (f_clr[g]),
      .kill_i (f_kill[g]),
      .q_o    (f_q[g])
    );
  end

  mbx_word #(.W(DATA_W)) u_h2d_word (
    .clk(clk), .rst_n(rst_n), .we_i(host_wr), .d_i(host_wdata), .q_o(h2d_word)
  );

  mbx_word #(.W(DATA_W)) u_d2h_word (
    .clk(clk), .rst_n(rst_n), .we_i(dsp_wr && at_data), .d_i(dsp_wdata), .q_o(d2h_word)
  );

  mbx_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_wr_i  (host_wr),
    .host_tag_i (host_tag),
    .ien_we_i   (dsp_wr && at_ien),
    .hirq_we_i  (dsp_wr && at_stat),
    .wbit_i     (dsp_wdata[1]),
    .ctl_wr_i   (host_ctl_wr),
    .ctl_run_i  (host_ctl_run),
    .tag_o      (v.tag),
    .dsp_en_o   (v.dsp_en),
    .hirq_o     (v.hirq),
    .run_o      (dsp_run),
    .release_o  (rel)
  );

  assign v.h2d_full = f_q[DIR_H2D];
  assign v.d2h_full = f_q[DIR_D2H];

  assign dsp_irq = !((!v.h2d_full && !v.dsp_en) || (v.d2h_full && v.dsp_en));

  assign host_rdata  = d2h_word;
  assign host_irq    = v.hirq;
  assign host_status = {v.h2d_full, v.d2h_full, !v.dsp_en, !v.hirq, {LOW_W{1'b1}}};

  always_comb begin
    dsp_rdata = '0;
    if (at_data)      dsp_rdata = h2d_word;
    else if (at_stat) dsp_rdata = {v.tag, v.h2d_full, v.d2h_full, 1'b0, {LOW_W{1'b1}}};
  end
endmodule

// File: rtl/mbx_checker.sv
module mbx_checker #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              host_wr,
  input logic              host_rd,
  input logic [DATA_W-1:0] host_rdata,
  input logic [DATA_W-1:0] host_status,
  input logic              host_irq,
  input logic              host_ctl_wr,
  input logic              host_ctl_run,
  input logic              dsp_run,
  input logic              dsp_rd,
  input logic              dsp_wr,
  input logic [ADDR_W-1:0] dsp_addr,
  input logic [DATA_W-1:0] dsp_wdata,
  input logic              dsp_irq
);
  logic rel;
  assign rel = host_ctl_wr && host_ctl_run && !dsp_run;

  // R1 and R10: a host write always leaves the host flag set
  a_r1_host_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr |=> host_status[DATA_W-1]);

  a_r2_dsp_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (dsp_rd && dsp_addr == '0 && !host_wr) |=> !host_status[DATA_W-1]);

  a_r3_dsp_word: assert property (@(posedge clk) disable iff (!rst_n)
    (dsp_wr && dsp_addr == '0 && !rel) |=> (host_status[DATA_W-2] && host_rdata == $past(dsp_wdata)));

  a_r3_host_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && !(dsp_wr && dsp_addr == '0)) |=> !host_status[DATA_W-2]);

  a_r4_enable_load: assert property (@(posedge clk) disable iff (!rst_n)
    (dsp_wr && dsp_addr == ADDR_W'(3) && !rel) |=> (host_status[DATA_W-3] == !$past(dsp_wdata[1])));

  a_r5_dsp_irq: assert property (@(posedge clk) disable iff (!rst_n)
    dsp_irq == !((!host_status[DATA_W-1] && host_status[DATA_W-3]) ||
                 (host_status[DATA_W-2] && !host_status[DATA_W-3])));

  a_r6_host_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (dsp_wr && dsp_addr == ADDR_W'(1)) |=> (host_irq == $past(dsp_wdata[1])));

  a_r7_status_low: assert property (@(posedge clk) disable iff (!rst_n)
    (&host_status[DATA_W-5:0]) && (host_status[DATA_W-4] == !host_irq));

  a_r9_release: assert property (@(posedge clk) disable iff (!rst_n)
    rel |=> (!host_status[DATA_W-2] && host_status[DATA_W-3] && dsp_run));

  a_r9_h2d_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (rel && !host_wr && !(dsp_rd && dsp_addr == '0)) |=> $stable(host_status[DATA_W-1]));
endmodule

bind dsp_mailbox mbx_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mbx_chk (
  .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
  .host_rdata(host_rdata), .host_status(host_status), .host_irq(host_irq),
  .host_ctl_wr(host_ctl_wr), .host_ctl_run(host_ctl_run), .dsp_run(dsp_run),
  .dsp_rd(dsp_rd), .dsp_wr(dsp_wr), .dsp_addr(dsp_addr), .dsp_wdata(dsp_wdata),
  .dsp_irq(dsp_irq)
);

// File: tb/tb_dsp_mailbox.sv
`timescale 1ns/1ps
module tb_dsp_mailbox;
  logic clk = 1'b0;
  logic rst_n;
  logic host_wr, host_tag, host_rd, host_ctl_wr, host_ctl_run;
  logic [15:0] host_wdata, host_rdata, host_status;
  logic host_irq, dsp_run, dsp_rd, dsp_wr, dsp_irq;
  logic [2:0] dsp_addr;
  logic [15:0] dsp_wdata, dsp_rdata;

  always #2 clk = ~clk;

  dsp_mailbox dut (.*);

  int n_chk = 0, n_fail = 0;
  logic m_h2d, m_d2h, m_tag, m_en, m_hirq, m_run;
  logic [15:0] m_hw, m_dw;

  function automatic logic [15:0] exp_hstat();
    return {m_h2d, m_d2h, !m_en, !m_hirq, 12'hFFF};
  endfunction
  function automatic logic [15:0] exp_drd();
    if (dsp_addr == 3'd0) return m_hw;
    if (dsp_addr == 3'd1) return {m_tag, m_h2d, m_d2h, 1'b0, 12'hFFF};
    return 16'h0;
  endfunction
  function automatic logic exp_irq();
    return !((!m_h2d && !m_en) || (m_d2h && m_en));
  endfunction

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    host_wr = 0; host_tag = 0; host_rd = 0; host_ctl_wr = 0; host_ctl_run = 0;
    dsp_rd = 0; dsp_wr = 0; dsp_addr = 3'd7; host_wdata = 0; dsp_wdata = 0;
  endtask

  // one clock: model update at the edge, compare at the following falling edge
  task automatic step();
    logic rel;
    @(posedge clk);
    rel = host_ctl_wr && host_ctl_run && !m_run;
    if (host_wr) m_hw = host_wdata;
    if (dsp_wr && dsp_addr == 3'd0) m_dw = dsp_wdata;
    if (host_wr) m_h2d = 1'b1; else if (dsp_rd && dsp_addr == 3'd0) m_h2d = 1'b0;
    if (rel) m_d2h = 1'b0;
    else if (dsp_wr && dsp_addr == 3'd0) m_d2h = 1'b1;
    else if (host_rd) m_d2h = 1'b0;
    if (rel) begin m_tag = 0; m_en = 0; end
    else begin
      if (host_wr) m_tag = host_tag;
      if (dsp_wr && dsp_addr == 3'd3) m_en = dsp_wdata[1];
    end
    if (dsp_wr && dsp_addr == 3'd1) m_hirq = dsp_wdata[1];
    if (host_ctl_wr) m_run = host_ctl_run;
    @(negedge clk);
  endtask

  task automatic check_all(string tagtxt);
    chk({tagtxt, " R7 host status"}, host_status, exp_hstat());
    chk({tagtxt, " R5 dsp irq"}, {15'd0, dsp_irq}, {15'd0, exp_irq()});
    chk({tagtxt, " R3 host word"}, host_rdata, m_dw);
    chk({tagtxt, " R8 dsp read"}, dsp_rdata, exp_drd());
    chk({tagtxt, " R6 host irq"}, {15'd0, host_irq}, {15'd0, m_hirq});
    chk({tagtxt, " R9 run"}, {15'd0, dsp_run}, {15'd0, m_run});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual expired expected done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'h1234_5eed));
    idle();
    m_h2d = 0; m_d2h = 0; m_tag = 0; m_en = 0; m_hirq = 0; m_run = 0; m_hw = 0; m_dw = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    // R11: reset values
    chk("R11 reset status", host_status, 16'h3FFF);
    chk("R11 reset irq", {15'd0, dsp_irq}, 16'd0);
    rst_n = 1;
    @(negedge clk);

    // R1: host write with tag
    host_wr = 1; host_tag = 1; host_wdata = 16'hA5C3; step(); idle();
    chk("R1 h2d flag", {15'd0, host_status[15]}, 16'd1);
    dsp_addr = 3'd1; #0.1;
    chk("R1 tag in dsp status", dsp_rdata, 16'hCFFF);
    // R2: DSP reads word then flag clears
    dsp_addr = 3'd0; dsp_rd = 1; #0.1;
    chk("R2 dsp sees host word", dsp_rdata, 16'hA5C3);
    step(); idle();
    chk("R2 h2d cleared", {15'd0, host_status[15]}, 16'd0);
    // R4: enable load and complement
    dsp_wr = 1; dsp_addr = 3'd3; dsp_wdata = 16'h0002; step(); idle();
    chk("R4 host-flag enable low", {15'd0, host_status[13]}, 16'd0);
    // R10: simultaneous set/clear of both flags
    host_wr = 1; host_wdata = 16'h1111; dsp_rd = 1; dsp_addr = 3'd0; step(); idle();
    chk("R10 h2d set wins", {15'd0, host_status[15]}, 16'd1);
    dsp_wr = 1; dsp_addr = 3'd0; dsp_wdata = 16'h7E57; host_rd = 1; step(); idle();
    chk("R10 d2h set wins", {15'd0, host_status[14]}, 16'd1);
    chk("R3 word stored", host_rdata, 16'h7E57);
    // R9: release edge with host flag full
    host_ctl_wr = 1; host_ctl_run = 1; step(); idle();
    chk("R9 release status", host_status, exp_hstat());
    chk("R9 h2d kept", {15'd0, host_status[15]}, 16'd1);
    chk("R9 d2h cleared", {15'd0, host_status[14]}, 16'd0);
    // R9: repeat control write at 1 is not a release
    dsp_wr = 1; dsp_addr = 3'd3; dsp_wdata = 16'h0002; step(); idle();
    host_ctl_wr = 1; host_ctl_run = 1; step(); idle();
    chk("R9 no second release", {15'd0, host_status[13]}, 16'd0);
    check_all("directed");

    for (int i = 0; i < 4000; i++) begin
      idle();
      host_wr     = ($urandom % 3) == 0;
      host_tag    = $urandom % 2;
      host_wdata  = 16'($urandom);
      host_rd     = ($urandom % 3) == 0;
      host_ctl_wr = ($urandom % 8) == 0;
      host_ctl_run = $urandom % 2;
      dsp_rd      = ($urandom % 3) == 0;
      dsp_wr      = ($urandom % 3) == 0;
      dsp_addr    = 3'($urandom);
      dsp_wdata   = 16'($urandom);
      #0.1;
      chk("R8 comb dsp read", dsp_rdata, exp_drd());
      step();
      check_all("random");
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule